// File: doc/BRIEF.md
# Frame-Based Transmit Event Scheduler

This block walks a table of transmit events held in a word-addressed memory, one frame per frame-start pulse. Each frame has a fixed allocation of event slots, and each slot is two words long. Only the first 2^m slots of the frame are fetched, where m is a configuration input. For each fetched event the block decodes a 4-bit scheduler number, a start flag and a 15-bit structure pointer. It then either issues a cell-assembly request or skips the event.

Requests leave through a valid/ready handshake. A request carries a 20-bit structure address, which is the pointer with five zero bits below it, and the scheduler number. Before the channel is marked initialised, nothing is issued until the walk reaches an event with its start flag set. From that event onward, every valid event executes. Frames are walked in turn and wrap back to frame 0 after the configured count. A frame pulse that arrives while a walk is still running is ignored and latches a sticky overrun flag.

Top module: `tx_event_walker`

## Requirements
- R1: Event k of frame f occupies the word addresses base + 2·E·f + 2k (first word) and the address one above it (second word), where E is the configured number of events per frame.
- R2: A walk fetches exactly the first 2^m events of the frame, in both words, and then goes idle; the remaining allocated slots are never read.
- R3: The scheduler number is bits 5:2 of the first word. The value 4'hF marks an invalid event, which produces no request; the values 0 to 14 are valid.
- R4: A request carries req_addr = {second word bits 14:0, 5'b00000} and req_sched = the scheduler number of the event.
- R5: Requests leave in the order of the events in the frame.
- R6: While cfg_initialised is 0, no request is issued until an event with the start flag (bit 0 of the first word) is reached. That event, if valid, and every valid event after it are executed, including those in later frames.
- R7: While cfg_initialised is 1, every valid event executes whether or not its start flag is set.
- R8: After frame cfg_frames−1 has been walked, the next frame pulse walks frame 0 again.
- R9: A frame pulse that arrives while busy is high has no effect on the walk and sets overrun, which stays set until reset.
- R10: While req_valid is high and req_ready is low, req_addr and req_sched hold steady and no memory read is issued.
- R11: After reset, busy, req_valid, mem_rd_en and overrun are 0, and the next walk covers frame 0.
- R12: Read data is taken one cycle after the read enable that addresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame-start pulse |
| cfg_base | input | ADDR_W | Word address of frame 0 |
| cfg_frame_events | input | EV_W | Event slots allocated per frame |
| cfg_read_exp | input | EXP_W | Exponent m; 2^m events fetched per frame |
| cfg_frames | input | FR_W | Number of frames in the table |
| cfg_initialised | input | 1 | Channel initialised; start flag no longer gates execution |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | ADDR_W | Memory word address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after mem_rd_en |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high with req_valid |
| req_addr | output | 20 | Structure address |
| req_sched | output | 4 | Scheduler number |
| busy | output | 1 | A frame walk is in progress |
| overrun | output | 1 | Sticky: frame pulse arrived during a walk |

## Verification
The bench uses the default widths: 16-bit addresses and data, an 8-bit event count and a 3-bit exponent. It programs a table of three frames with six slots each at base 16, and switches m between 2 and 1. With this setup the unread tail slots, the wrap from frame 2 back to frame 0 and the frame-offset arithmetic all fall within a 128-word memory model. It also brings the start flag in the middle of a frame, an invalid event carrying a start flag, back-pressure from a toggling or held ready, and a pulse that lands inside a stalled walk within a few hundred cycles.

// File: rtl/tx_event_walker.sv
module tx_event_walker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int EV_W   = 8,
  parameter int EXP_W  = 3,
  parameter int FR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [EV_W-1:0]   cfg_frame_events,
  input  logic [EXP_W-1:0]  cfg_read_exp,
  input  logic [FR_W-1:0]   cfg_frames,
  input  logic              cfg_initialised,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [19:0]       req_addr,
  output logic [3:0]        req_sched,
  output logic              busy,
  output logic              overrun
);
  localparam int CNT_W = 1 << EXP_W;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_W0, S_W1, S_REQ} st_t;
  st_t state;

  logic [CNT_W-1:0]  ev_idx;
  logic [FR_W-1:0]   frame_idx;
  logic [ADDR_W-1:0] frame_off;
  logic [5:0]        w0;
  logic              started;

  logic [CNT_W-1:0]  last_idx;
  logic [ADDR_W-1:0] stride, ev_addr;
  logic              valid_ev, fire, advance, last_ev, wrap;

  assign last_idx  = (CNT_W'(1) << cfg_read_exp) - CNT_W'(1);
  assign stride    = ADDR_W'({cfg_frame_events, 1'b0});
  assign ev_addr   = cfg_base + frame_off + ADDR_W'({ev_idx, 1'b0});
  assign valid_ev  = w0[5:2] != 4'hF;
  assign fire      = valid_ev && (cfg_initialised || started || w0[0]);
  assign advance   = (state == S_W1 && !fire) || (state == S_REQ && req_ready);
  assign last_ev   = ev_idx == last_idx;
  assign wrap      = (FR_W'(frame_idx + 1'b1) >= cfg_frames) || (frame_idx == '1);

  assign mem_rd_en   = (state == S_RD0) || (state == S_W0);
  assign mem_rd_addr = ev_addr + ADDR_W'(state == S_W0);
  assign busy        = state != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ev_idx    <= '0;
      frame_idx <= '0;
      frame_off <= '0;
      w0        <= '0;
      started   <= 1'b0;
      overrun   <= 1'b0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_sched <= '0;
    end else begin
      if (frame_tick && state != S_IDLE) overrun <= 1'b1;
      case (state)
        S_IDLE: if (frame_tick) begin
          ev_idx <= '0;
          state  <= S_RD0;
        end
        S_RD0: state <= S_W0;
        S_W0: begin
          w0    <= mem_rd_data[5:0];
          state <= S_W1;
        end
        S_W1: begin
          if (w0[0]) started <= 1'b1;
          if (fire) begin
            req_valid <= 1'b1;
            req_addr  <= {mem_rd_data[14:0], 5'b00000};
            req_sched <= w0[5:2];
            state     <= S_REQ;
          end
        end
        S_REQ: if (req_ready) req_valid <= 1'b0;
        default: state <= S_IDLE;
      endcase
      if (advance) begin
        if (last_ev) begin
          state <= S_IDLE;
          if (wrap) begin
            frame_idx <= '0;
            frame_off <= '0;
          end else begin
            frame_idx <= frame_idx + 1'b1;
            frame_off <= frame_off + stride;
          end
        end else begin
          ev_idx <= ev_idx + 1'b1;
          state  <= S_RD0;
        end
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_sched));

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !mem_rd_en);

  // R3
  no_invalid_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_sched != 4'hF);

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[4:0] == 5'd0);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(frame_tick && busy));

endmodule

// File: tb/tx_event_walker_tb.sv
`timescale 1ns/1ps
module tx_event_walker_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        frame_tick = 0;
  logic [15:0] cfg_base = 16'd16;
  logic [7:0]  cfg_frame_events = 8'd6;
  logic [2:0]  cfg_read_exp = 3'd2;
  logic [7:0]  cfg_frames = 8'd3;
  logic        cfg_initialised = 0;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [15:0] mem_rd_data = 0;
  logic        req_valid;
  logic        req_ready = 1;
  logic [19:0] req_addr;
  logic [3:0]  req_sched;
  logic        busy, overrun;

  int checks = 0, failures = 0;
  logic [15:0] mem [0:127];
  int rd_n = 0, rq_n = 0;
  logic [15:0] rd_log [0:63];
  logic [19:0] rq_addr [0:63];
  logic [3:0]  rq_sched [0:63];
  bit toggle_ready = 0, hold_ready = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tx_event_walker u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cfg_base(cfg_base),
    .cfg_frame_events(cfg_frame_events), .cfg_read_exp(cfg_read_exp),
    .cfg_frames(cfg_frames), .cfg_initialised(cfg_initialised),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_sched(req_sched), .busy(busy), .overrun(overrun));

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[6:0]];

  always @(negedge clk) begin
    if (mem_rd_en && rd_n < 64) begin rd_log[rd_n] = mem_rd_addr; rd_n++; end
    if (req_valid && req_ready && rq_n < 64) begin
      rq_addr[rq_n] = req_addr; rq_sched[rq_n] = req_sched; rq_n++;
    end
  end

  initial forever begin
    @(posedge clk); #1; cyc++;
    req_ready = hold_ready ? 1'b0 : (toggle_ready ? cyc[0] : 1'b1);
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] ptr(input int f, input int k);
    return 15'h4000 + 15'(f * 16 + k);
  endfunction

  task automatic put_ev(input int f, input int k, input int sched, input bit st);
    int a = 16 + 12 * f + 2 * k;
    mem[a]     = 16'({sched[3:0], 1'b0, st});
    mem[a + 1] = {1'b0, ptr(f, k)};
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic walk();
    rd_n = 0; rq_n = 0;
    @(posedge clk); #1 frame_tick = 1;
    @(posedge clk); #1 frame_tick = 0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic chk_req(input int i, input int sched, input int f, input int k, input string tag);
    check(rq_sched[i] == 4'(sched), tag, rq_sched[i], sched);
    check(rq_addr[i] == {ptr(f, k), 5'b0}, tag, rq_addr[i], {ptr(f, k), 5'b0});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !req_valid && !mem_rd_en && !overrun, "R11 reset state",
          {busy, req_valid, mem_rd_en, overrun}, 0);
  endtask

  task automatic t_start_flag();
    cfg_initialised = 0; cfg_read_exp = 2;
    put_ev(0, 0, 3, 0); put_ev(0, 1, 5, 1); put_ev(0, 2, 15, 0); put_ev(0, 3, 7, 0);
    put_ev(0, 4, 1, 0); put_ev(0, 5, 1, 0);
    walk();
    check(rd_n == 8, "R2 reads per frame m=2", rd_n, 8);
    check(rd_log[0] == 16, "R1/R11 first read frame 0", rd_log[0], 16);
    check(rd_log[1] == 17, "R12 second word address", rd_log[1], 17);
    check(rd_log[7] == 23, "R2 last read address", rd_log[7], 23);
    check(rq_n == 2, "R6/R3 request count", rq_n, 2);
    chk_req(0, 5, 0, 1, "R6 start-flag event executes");
    chk_req(1, 7, 0, 3, "R3/R4 invalid skipped, next event");
  endtask

  task automatic t_order_backpressure();
    for (int k = 0; k < 4; k++) put_ev(1, k, k + 8, 0);
    toggle_ready = 1;
    walk();
    toggle_ready = 0;
    check(rd_log[0] == 28, "R1 frame 1 offset", rd_log[0], 28);
    check(rq_n == 4, "R6/R10 started persists, all issued", rq_n, 4);
    for (int k = 0; k < 4; k++) chk_req(k, k + 8, 1, k, "R5 order");
  endtask

  task automatic t_frame2();
    cfg_initialised = 1; cfg_read_exp = 1;
    put_ev(2, 0, 15, 1); put_ev(2, 1, 14, 0);
    walk();
    check(rd_n == 4, "R2 reads per frame m=1", rd_n, 4);
    check(rd_log[0] == 40, "R1 frame 2 offset", rd_log[0], 40);
    check(rq_n == 1, "R3 invalid with start flag skipped", rq_n, 1);
    chk_req(0, 14, 2, 1, "R4 scheduler 14 valid");
  endtask

  task automatic t_wrap();
    walk();
    check(rd_log[0] == 16, "R8 wrap to frame 0", rd_log[0], 16);
    check(rq_n == 2, "R8 wrap request count", rq_n, 2);
  endtask

  task automatic t_init_set();
    do_reset();
    cfg_initialised = 1; cfg_read_exp = 1;
    walk();
    check(rq_n == 2, "R7 all valid execute when initialised", rq_n, 2);
    chk_req(0, 3, 0, 0, "R7 event without start flag");
  endtask

  task automatic t_overrun();
    hold_ready = 1;
    rd_n = 0; rq_n = 0;
    @(posedge clk); #1 frame_tick = 1;
    @(posedge clk); #1 frame_tick = 0;
    for (int i = 0; i < 200 && !req_valid; i++) @(negedge clk);
    check(req_valid && !mem_rd_en, "R10 stalled with request pending", mem_rd_en, 0);
    @(posedge clk); #1 frame_tick = 1;
    @(posedge clk); #1 frame_tick = 0;
    repeat (3) @(negedge clk);
    check(overrun == 1, "R9 overrun set", overrun, 1);
    check(rd_n == 2, "R10 no reads while stalled", rd_n, 2);
    hold_ready = 0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    check(rd_n == 4, "R9 walk not restarted", rd_n, 4);
    check(rq_n == 2, "R9 frame 1 requests", rq_n, 2);
    walk();
    check(rd_log[0] == 40, "R9 ignored tick did not advance frame", rd_log[0], 40);
    check(overrun == 1, "R9 overrun sticky", overrun, 1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 16'h003C;
    do_reset();
    t_reset();
    t_start_flag();
    t_order_backpressure();
    t_frame2();
    t_wrap();
    t_init_set();
    t_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule